// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a four-bank SDRAM on every rising clock edge and tells the rest of the controller or monitor what each command did. It decodes the active-low row strobe, column strobe and write enable together with chip select, a 12-bit address and a 2-bit bank index. It keeps an open or idle flag and the most recently activated row for every bank. All four banks can hold different rows at the same time.

Each accepted command produces a one-cycle report. The report carries the command code, the bank, the row or column address, and flags for auto-precharge and precharge-all. A command that makes no sense for the current bank state gives a one-cycle illegal pulse instead, and the bank state does not change. Examples are opening a bank that is already open, a burst to an idle bank, or a refresh while any bank is open.

Address bit 8 has two roles. On a precharge it chooses between all banks and one bank. On a read or write it requests auto-precharge. Deselect stops decoding, but open banks stay open.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is low and after it is released, every bank is idle and every report output (cmdValid, illegal, cmdKind, cmdBank, cmdAddr, autoPre, preAll) is zero.
- R2: With csN high on a clock edge, no report and no illegal pulse are produced, and no bank's open state or row changes, whatever the other inputs hold.
- R3: {rasN,casN,weN} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register-set and 111 no-operation. No-operation produces no report. 110 raises illegal. Mode-register-set is always accepted and reports all 12 address bits.
- R4: An activate to an idle bank opens that bank, stores all 12 address bits as its row, and reports that row on cmdAddr.
- R5: A read or write to an open bank is accepted and reports only address bits 7..0 as the column on cmdAddr, with cmdAddr bits 11..8 zero.
- R6: On an accepted read or write, address bit 8 high sets autoPre and leaves the bank idle afterwards. Bit 8 low clears autoPre and the bank stays open.
- R7: A precharge is always accepted. Address bit 8 high closes all four banks and sets preAll. Bit 8 low closes only the selected bank and clears preAll.
- R8: The bank index is {BA1,BA0}, so bankSel = 2'b01 addresses bank 1, and cmdBank reports that index for every accepted command.
- R9: An activate to an open bank, or a read or write to an idle bank, raises illegal for one cycle, produces no report and leaves every bank's state unchanged.
- R10: A refresh is accepted only when all banks are idle; otherwise it raises illegal.
- R11: The four banks are independent: each open bank exposes its own stored row on openRows[12*b +: 12].
- R12: Results appear on the outputs one clock edge after the command is sampled and last one cycle. When cmdValid is low, cmdKind, cmdBank, cmdAddr, autoPre and preAll are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 12 | Row, column or mode address; bit 8 doubles as auto/all-precharge |
| bankSel | input | 2 | Bank index {BA1,BA0} |
| cmdValid | output | 1 | One-cycle strobe for an accepted command |
| cmdKind | output | 3 | Accepted command code {rasN,casN,weN} |
| cmdBank | output | 2 | Bank of the accepted command |
| cmdAddr | output | 12 | Row for activate, column for read/write, mode value for mode-register-set |
| autoPre | output | 1 | Read/write carried auto-precharge |
| preAll | output | 1 | Precharge targeted all banks |
| illegal | output | 1 | One-cycle pulse for a command that conflicts with bank state |
| bankOpen | output | 4 | Open flag per bank |
| openRows | output | 48 | Stored row per bank, 12 bits each |

## Verification
The hardest state to reach from the ports is all four banks open at once with different rows. Only then can a refresh be refused and a single-bank precharge be shown to spare its neighbours. Random traffic rarely gets there, because any precharge-all or auto-precharge tears the set down. The stimulus therefore opens every bank with distinct rows in a directed prologue. Deselect, refusal and selective-close cases run against that full set. A seeded random phase then mixes all codes, with activates weighted up, to reach further mixed states.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  // Command code as seen on {rasN, casN, weN}
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BAD = 3'b110,
    CMD_NOP = 3'b111
  } cmdCode_e;

  // Strobes from the decoder to the bank datapath
  typedef struct packed {
    logic openEn;
    logic closeOne;
    logic closeAll;
  } bankStrobe_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 8,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output bankStrobe_t          strobe,
  output logic                 cmdValid,
  output logic [2:0]           cmdKind,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic                 autoPre,
  output logic                 preAll,
  output logic                 illegal
);

  cmdCode_e          code;
  logic              selOpen;
  logic              allIdle;
  logic              apFlag;
  logic              accept;
  logic              reject;
  logic [ADDR_W-1:0] nextAddr;
  logic              nextAp;
  logic              nextAll;

  assign code    = cmdCode_e'({rasN, casN, weN});
  assign selOpen = bankOpen[bankSel];
  assign allIdle = ~|bankOpen;
  assign apFlag  = addr[AP_BIT];

  always_comb begin
    accept   = 1'b0;
    reject   = 1'b0;
    strobe   = '0;
    nextAddr = '0;
    nextAp   = 1'b0;
    nextAll  = 1'b0;
    if (!csN) begin
      unique case (code)
        CMD_ACT: begin
          if (selOpen) reject = 1'b1;
          else begin
            accept        = 1'b1;
            strobe.openEn = 1'b1;
            nextAddr      = addr;
          end
        end
        CMD_RD, CMD_WR: begin
          if (!selOpen) reject = 1'b1;
          else begin
            accept          = 1'b1;
            nextAddr        = ADDR_W'(addr[COL_W-1:0]);
            nextAp          = apFlag;
            strobe.closeOne = apFlag;
          end
        end
        CMD_PRE: begin
          accept          = 1'b1;
          nextAll         = apFlag;
          strobe.closeAll = apFlag;
          strobe.closeOne = !apFlag;
        end
        CMD_REF: begin
          if (allIdle) accept = 1'b1;
          else reject = 1'b1;
        end
        CMD_MRS: begin
          accept   = 1'b1;
          nextAddr = addr;
        end
        CMD_NOP: ;
        default: reject = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKind  <= '0;
      cmdBank  <= '0;
      cmdAddr  <= '0;
      autoPre  <= 1'b0;
      preAll   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      cmdValid <= accept;
      cmdKind  <= accept ? code : 3'b000;
      cmdBank  <= accept ? bankSel : '0;
      cmdAddr  <= nextAddr;
      autoPre  <= nextAp;
      preAll   <= nextAll;
      illegal  <= reject;
    end
  end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bankStrobe_t                 strobe,
  input  logic [BANK_W-1:0]           bankSel,
  input  logic [ADDR_W-1:0]           rowIn,
  output logic [NUM_BANKS-1:0]        bankOpen,
  output logic [NUM_BANKS*ADDR_W-1:0] openRows
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              isMine;
    logic [ADDR_W-1:0] rowQ;

    assign isMine = (bankSel == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[g] <= 1'b0;
        rowQ        <= '0;
      end else if (strobe.closeAll) begin
        bankOpen[g] <= 1'b0;
      end else if (isMine && strobe.openEn) begin
        bankOpen[g] <= 1'b1;
        rowQ        <= rowIn;
      end else if (isMine && strobe.closeOne) begin
        bankOpen[g] <= 1'b0;
      end
    end

    assign openRows[g*ADDR_W +: ADDR_W] = rowQ;
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 8,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        csN,
  input  logic                        rasN,
  input  logic                        casN,
  input  logic                        weN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           bankSel,
  output logic                        cmdValid,
  output logic [2:0]                  cmdKind,
  output logic [BANK_W-1:0]           cmdBank,
  output logic [ADDR_W-1:0]           cmdAddr,
  output logic                        autoPre,
  output logic                        preAll,
  output logic                        illegal,
  output logic [NUM_BANKS-1:0]        bankOpen,
  output logic [NUM_BANKS*ADDR_W-1:0] openRows
);

  bankStrobe_t strobe;

  sdram_cmd_ctrl #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .bankSel(bankSel), .bankOpen(bankOpen), .strobe(strobe),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .autoPre(autoPre), .preAll(preAll), .illegal(illegal)
  );

  sdram_bank_state #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_banks (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankSel(bankSel),
    .rowIn(addr), .bankOpen(bankOpen), .openRows(openRows)
  );

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        csN,
  input logic                        cmdValid,
  input logic [2:0]                  cmdKind,
  input logic [BANK_W-1:0]           cmdBank,
  input logic [ADDR_W-1:0]           cmdAddr,
  input logic                        autoPre,
  input logic                        preAll,
  input logic                        illegal,
  input logic [NUM_BANKS-1:0]        bankOpen,
  input logic [NUM_BANKS*ADDR_W-1:0] openRows
);

  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> (!cmdValid && !illegal));

  p_deselect_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> (bankOpen == $past(bankOpen) && openRows == $past(openRows)));

  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 3'b011) |-> bankOpen[cmdBank]);

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (bankOpen == $past(bankOpen) && !cmdValid));

  p_refresh_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 3'b001) |-> ($past(bankOpen) == '0));

  p_pre_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && preAll) |-> (bankOpen == '0));

  p_quiet_fields_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmdKind == 3'b000 && cmdBank == '0 && cmdAddr == '0 && !autoPre && !preAll));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csN, rasN, casN, weN;
  logic [11:0] addr;
  logic [1:0]  bankSel;
  logic        cmdValid, autoPre, preAll, illegal;
  logic [2:0]  cmdKind;
  logic [1:0]  cmdBank;
  logic [11:0] cmdAddr;
  logic [3:0]  bankOpen;
  logic [47:0] openRows;

  int checks = 0;
  int fails  = 0;

  logic [3:0]  mOpen;
  logic [11:0] mRow [4];

  always #5 clk = ~clk;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .bankSel(bankSel), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr), .autoPre(autoPre), .preAll(preAll),
    .illegal(illegal), .bankOpen(bankOpen), .openRows(openRows)
  );

  function automatic logic [24:0] pack_out();
    return {cmdValid, illegal, cmdKind, cmdBank, cmdAddr, autoPre, preAll, bankOpen};
  endfunction

  task automatic check_vec(input string tag, input logic [24:0] got, input logic [24:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s outputs got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_rows(input string tag);
    for (int b = 0; b < 4; b++) begin
      if (mOpen[b]) begin
        checks++;
        if (openRows[b*12 +: 12] !== mRow[b]) begin
          fails++;
          $display("FAIL %s bank %0d row got %h expected %h", tag, b, openRows[b*12 +: 12], mRow[b]);
        end
      end
    end
  endtask

  // Drive one command, predict from the requirement model, compare after the edge.
  task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                       input logic [11:0] a, input logic [1:0] b, input string tag);
    logic v, bad, ap, pa;
    logic [11:0] oa;
    logic [3:0]  nOpen;
    logic [11:0] nRow [4];
    logic [24:0] expV;
    int bi;
    bi = b; v = 0; bad = 0; ap = 0; pa = 0; oa = '0; nOpen = mOpen;
    for (int i = 0; i < 4; i++) nRow[i] = mRow[i];
    if (!c) begin
      case ({r, ca, w})
        3'b011: if (mOpen[bi]) bad = 1; else begin v = 1; oa = a; nOpen[bi] = 1; nRow[bi] = a; end
        3'b101, 3'b100: if (!mOpen[bi]) bad = 1;
                        else begin v = 1; oa = {4'h0, a[7:0]}; ap = a[8]; if (a[8]) nOpen[bi] = 0; end
        3'b010: begin v = 1; pa = a[8]; if (a[8]) nOpen = 4'h0; else nOpen[bi] = 0; end
        3'b001: if (mOpen != 0) bad = 1; else v = 1;
        3'b000: begin v = 1; oa = a; end
        3'b111: ;
        default: bad = 1;
      endcase
    end
    @(negedge clk);
    csN = c; rasN = r; casN = ca; weN = w; addr = a; bankSel = b;
    @(posedge clk);
    #1;
    expV = {v, bad, v ? {r, ca, w} : 3'b000, v ? b : 2'b00, oa, ap, pa, nOpen};
    mOpen = nOpen;
    for (int i = 0; i < 4; i++) mRow[i] = nRow[i];
    check_vec(tag, pack_out(), expV);
    check_rows("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] code;
    void'($urandom(32'd20240611));
    rstN = 0; csN = 1; rasN = 1; casN = 1; weN = 1; addr = '0; bankSel = '0;
    mOpen = '0;
    for (int i = 0; i < 4; i++) mRow[i] = '0;
    repeat (3) @(posedge clk);
    #1 check_vec("R1", pack_out(), 25'd0);
    @(negedge clk) rstN = 1;
    @(posedge clk); #1 check_vec("R1", pack_out(), 25'd0);

    // Open every bank with distinct rows; bankSel 01 is bank 1
    issue(0, 0, 1, 1, 12'hABC, 2'b01, "R8");
    issue(0, 0, 1, 1, 12'h123, 2'b10, "R4");
    issue(0, 0, 1, 1, 12'hFFF, 2'b00, "R4");
    issue(0, 0, 1, 1, 12'h555, 2'b11, "R11");
    issue(0, 0, 1, 1, 12'h000, 2'b01, "R9");   // activate to open bank
    issue(0, 1, 0, 1, 12'hE3C, 2'b01, "R5");   // read, column only, A8 low
    issue(1, 0, 1, 1, 12'h777, 2'b01, "R2");   // deselected activate
    issue(1, 0, 1, 0, 12'h100, 2'b11, "R2");   // deselected precharge-all
    issue(0, 0, 0, 1, 12'h000, 2'b00, "R10");  // refresh with banks open
    issue(0, 1, 0, 0, 12'h1A5, 2'b11, "R6");   // write with auto-precharge
    issue(0, 1, 0, 1, 12'h010, 2'b11, "R9");   // read to idle bank
    issue(0, 1, 0, 0, 12'h0FF, 2'b00, "R6");   // write, bank stays open
    issue(0, 0, 1, 0, 12'h000, 2'b10, "R7");   // precharge one bank
    issue(0, 0, 1, 0, 12'h100, 2'b00, "R7");   // precharge all
    issue(0, 0, 0, 1, 12'h000, 2'b10, "R10");  // refresh all idle
    issue(0, 1, 1, 0, 12'h000, 2'b00, "R3");   // undefined code
    issue(0, 0, 0, 0, 12'h033, 2'b01, "R3");   // mode register set
    issue(0, 1, 1, 1, 12'hFFF, 2'b11, "R12");  // nop clears report

    for (int n = 0; n < 600; n++) begin
      code = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) code = 3'b011;
      issue(($urandom_range(0, 9) == 0), code[2], code[1], code[0],
            12'($urandom), 2'($urandom), "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule